// File: doc/BRIEF.md
# Register Rename Map with Short-Lived Result Detection

This block gives every architectural destination register a fresh physical result slot and looks up the current home of every source register. Each map entry holds a slot number and a location flag. Location 0 means the newest value is waiting in the reorder buffer at that slot. Location 1 means it has reached the architectural register file. Slots are handed out by a simple in-order allocator that runs over the reorder buffer's index space. The oldest slot is freed by a commit.

Besides the map, the block keeps one "superseded" flag per physical slot. The flag is raised when the architectural register that the slot was allocated for is given a newer slot. A result whose flag is already raised when it is produced is short-lived: every consumer has already picked it up from the forwarding buses, so nothing is gained by caching it in a small result cache. The execution pipeline asks about a slot one cycle before writeback, and the answer is returned on the writeback cycle together with the result.

A group of up to `LANES` rename requests arrives on a valid/ready stream. The lanes are in program order. Lookup results are combinational and valid in the cycle of the handshake. `ren_ready` may depend on the group's destination enables but never on `ren_valid`. A producer that sees `ren_ready` low holds the group unchanged until it is accepted. Commit, flush and the short-lived query are plain control pins.

Top module: `rename_table`

## Requirements
- R1: After reset, every architectural register looks up as location 1 with slot field 0, no slot is superseded, and the first destination is given slot 0 with all `SLOTS` slots free.
- R2: A source lane returns the slot and location held in the map for that register, where location 0 means the reorder buffer and location 1 means the register file. The lookup reflects the state before this cycle's commit.
- R3: In an accepted group, lanes with a destination receive consecutive slots (modulo `SLOTS`) in lane order, starting at the allocation pointer. The pointer then advances by the number of destinations.
- R4: `ren_ready` is 1 exactly when no flush is asserted and the free-slot count is at least the number of destinations in the group. Without a handshake neither the map, the flags nor the allocator change.
- R5: A source or a destination in lane k that names the destination of an earlier lane j<k in the same group sees lane j's new slot with location 0, not the stored map entry.
- R6: Each destination reports the previous slot and location for its register (`prev_slot`, `prev_loc`). When the previous location is 0, the superseded flag of that previous slot is set.
- R7: Allocating a slot as a new destination clears its superseded flag. A set caused by a later lane of the same group takes effect after the clear.
- R8: A query with `qry_valid` in cycle N gives `wb_valid`=1 in cycle N+1. In that cycle `wb_short` equals the flag of `qry_slot` as held during cycle N. Without a query, `wb_valid` is 0 one cycle later.
- R9: A commit of (`cmt_slot`, `cmt_arch`) changes the location of `cmt_arch` to 1 only if the map holds exactly that slot with location 0; otherwise the map is unchanged. Each commit frees one slot. A same-cycle rename of the same register overrides the commit.
- R10: A flush sets every map entry to location 1 with slot 0, clears all flags, resets the allocator to slot 0 with all slots free, holds `ren_ready` low and ignores a same-cycle commit.
- R11: Renaming a register whose map entry has location 1 sets no superseded flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename group present |
| ren_ready | output | 1 | Group can be accepted this cycle |
| ren_dst_en | input | LANES | Per-lane destination present |
| ren_dst | input | LANES x AW | Per-lane architectural destination |
| ren_src0 | input | LANES x AW | Per-lane first source register |
| ren_src1 | input | LANES x AW | Per-lane second source register |
| src0_slot | output | LANES x SW | Slot of first source |
| src0_loc | output | LANES | Location of first source (0 reorder buffer, 1 register file) |
| src1_slot | output | LANES x SW | Slot of second source |
| src1_loc | output | LANES | Location of second source |
| dst_slot | output | LANES x SW | Slot given to each destination |
| prev_slot | output | LANES x SW | Slot previously mapped to the destination register |
| prev_loc | output | LANES | Location previously mapped to the destination register |
| cmt_valid | input | 1 | Oldest slot commits |
| cmt_slot | input | SW | Committing slot |
| cmt_arch | input | AW | Architectural register of the committing slot |
| flush | input | 1 | Discard all in-flight renames |
| qry_valid | input | 1 | Short-lived query, one cycle before writeback |
| qry_slot | input | SW | Slot being produced |
| wb_valid | output | 1 | Query answer valid (writeback cycle) |
| wb_short | output | 1 | Result is short-lived |

## Verification
A wrong map entry shows up on the source lookup ports as soon as a later group reads that register, often many cycles after the faulty update. The bench therefore reads every map entry in turn after each directed phase and checks every lookup in a long mixed run. A wrong superseded flag is visible only through the query port, one cycle after the query. The bench queries slots right after they are superseded, reallocated and flushed. Allocator faults appear at once on `dst_slot` or `ren_ready`, because every cycle's slots and readiness are compared against an arithmetic model of the pointer and the free count.

// File: rtl/rn_pkg.sv
package rn_pkg;
  // Where the newest value of an architectural register lives.
  typedef enum logic {
    LOC_ROB = 1'b0,
    LOC_ARF = 1'b1
  } loc_e;

  localparam int unsigned DEF_ARCH_REGS = 8;
  localparam int unsigned DEF_SLOTS     = 16;
  localparam int unsigned DEF_LANES     = 2;
endpackage

// File: rtl/rn_alloc.sv
// In-order slot allocator: pointer plus free count.
module rn_alloc #(
  parameter int SLOTS = rn_pkg::DEF_SLOTS,
  parameter int LANES = rn_pkg::DEF_LANES,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      fire,
  input  logic                      cmt_valid,
  input  logic [LANES-1:0]          dst_en,
  output logic [LANES-1:0][SW-1:0]  new_slot,
  output logic                      room_ok,
  output logic [SW:0]               free_cnt
);
  localparam logic [SW:0] SLOTS_V = SLOTS[SW:0];

  logic [SW-1:0] head;
  logic [SW:0]   need;

  function automatic logic [SW-1:0] wrap_add(input logic [SW-1:0] base, input logic [SW:0] inc);
    logic [SW:0] sum;
    sum = {1'b0, base} + inc;
    if (sum >= SLOTS_V) sum = sum - SLOTS_V;
    return sum[SW-1:0];
  endfunction

  always_comb begin
    need = '0;
    for (int k = 0; k < LANES; k++) begin
      new_slot[k] = wrap_add(head, need);
      if (dst_en[k]) need = need + 1'b1;
    end
  end

  assign room_ok = (free_cnt >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head     <= '0;
      free_cnt <= SLOTS_V;
    end else if (flush) begin
      head     <= '0;
      free_cnt <= SLOTS_V;
    end else begin
      if (fire) head <= wrap_add(head, need);
      free_cnt <= free_cnt - (fire ? need : '0) + {{SW{1'b0}}, cmt_valid};
    end
  end
endmodule

// File: rtl/rn_map.sv
// Architectural map with same-group bypass, commit and flush.
module rn_map #(
  parameter int ARCH_REGS = rn_pkg::DEF_ARCH_REGS,
  parameter int SLOTS     = rn_pkg::DEF_SLOTS,
  parameter int LANES     = rn_pkg::DEF_LANES,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int SW = $clog2(SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      fire,
  input  logic [LANES-1:0]          dst_en,
  input  logic [LANES-1:0][AW-1:0]  dst,
  input  logic [LANES-1:0][AW-1:0]  src0,
  input  logic [LANES-1:0][AW-1:0]  src1,
  input  logic [LANES-1:0][SW-1:0]  new_slot,
  input  logic                      cmt_valid,
  input  logic [SW-1:0]             cmt_slot,
  input  logic [AW-1:0]             cmt_arch,
  output logic [LANES-1:0][SW-1:0]  s0_slot,
  output logic [LANES-1:0]          s0_loc,
  output logic [LANES-1:0][SW-1:0]  s1_slot,
  output logic [LANES-1:0]          s1_loc,
  output logic [LANES-1:0][SW-1:0]  old_slot,
  output logic [LANES-1:0]          old_loc,
  output logic [ARCH_REGS-1:0]      loc_vec
);
  import rn_pkg::*;

  logic [SW-1:0] map_slot [ARCH_REGS];
  logic          map_loc  [ARCH_REGS];
  logic [SW-1:0] w_slot   [ARCH_REGS];
  logic          w_loc    [ARCH_REGS];

  // Program-order view: each lane sees the writes of earlier lanes.
  always_comb begin
    for (int a = 0; a < ARCH_REGS; a++) begin
      w_slot[a] = map_slot[a];
      w_loc[a]  = map_loc[a];
    end
    for (int k = 0; k < LANES; k++) begin
      s0_slot[k]  = w_slot[src0[k]];
      s0_loc[k]   = w_loc[src0[k]];
      s1_slot[k]  = w_slot[src1[k]];
      s1_loc[k]   = w_loc[src1[k]];
      old_slot[k] = w_slot[dst[k]];
      old_loc[k]  = w_loc[dst[k]];
      if (dst_en[k]) begin
        w_slot[dst[k]] = new_slot[k];
        w_loc[dst[k]]  = LOC_ROB;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < ARCH_REGS; a++) begin
        map_slot[a] <= '0;
        map_loc[a]  <= LOC_ARF;
      end
    end else if (flush) begin
      for (int a = 0; a < ARCH_REGS; a++) begin
        map_slot[a] <= '0;
        map_loc[a]  <= LOC_ARF;
      end
    end else begin
      if (cmt_valid && map_loc[cmt_arch] == LOC_ROB && map_slot[cmt_arch] == cmt_slot)
        map_loc[cmt_arch] <= LOC_ARF;
      if (fire) begin
        for (int k = 0; k < LANES; k++) begin
          if (dst_en[k]) begin
            map_slot[dst[k]] <= new_slot[k];
            map_loc[dst[k]]  <= LOC_ROB;
          end
        end
      end
    end
  end

  always_comb begin
    for (int a = 0; a < ARCH_REGS; a++) loc_vec[a] = map_loc[a];
  end
endmodule

// File: rtl/rn_superseded.sv
// Per-slot superseded flags and the short-lived query stage.
module rn_superseded #(
  parameter int SLOTS = rn_pkg::DEF_SLOTS,
  parameter int LANES = rn_pkg::DEF_LANES,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      fire,
  input  logic [LANES-1:0]          dst_en,
  input  logic [LANES-1:0][SW-1:0]  new_slot,
  input  logic [LANES-1:0][SW-1:0]  old_slot,
  input  logic [LANES-1:0]          old_loc,
  input  logic                      qry_valid,
  input  logic [SW-1:0]             qry_slot,
  output logic                      wb_valid,
  output logic                      wb_short,
  output logic [SLOTS-1:0]          flags
);
  import rn_pkg::*;

  logic [SLOTS-1:0] flags_nxt;

  always_comb begin
    flags_nxt = flags;
    if (fire) begin
      for (int k = 0; k < LANES; k++) begin
        if (dst_en[k]) begin
          flags_nxt[new_slot[k]] = 1'b0;
          if (old_loc[k] == LOC_ROB) flags_nxt[old_slot[k]] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else if (flush) flags <= '0;
    else flags <= flags_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_short <= 1'b0;
    end else begin
      wb_valid <= qry_valid;
      wb_short <= qry_valid & flags[qry_slot];
    end
  end
endmodule

// File: rtl/rename_table.sv
module rename_table #(
  parameter int ARCH_REGS = rn_pkg::DEF_ARCH_REGS,
  parameter int SLOTS     = rn_pkg::DEF_SLOTS,
  parameter int LANES     = rn_pkg::DEF_LANES,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int SW = $clog2(SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ren_valid,
  output logic                      ren_ready,
  input  logic [LANES-1:0]          ren_dst_en,
  input  logic [LANES-1:0][AW-1:0]  ren_dst,
  input  logic [LANES-1:0][AW-1:0]  ren_src0,
  input  logic [LANES-1:0][AW-1:0]  ren_src1,
  output logic [LANES-1:0][SW-1:0]  src0_slot,
  output logic [LANES-1:0]          src0_loc,
  output logic [LANES-1:0][SW-1:0]  src1_slot,
  output logic [LANES-1:0]          src1_loc,
  output logic [LANES-1:0][SW-1:0]  dst_slot,
  output logic [LANES-1:0][SW-1:0]  prev_slot,
  output logic [LANES-1:0]          prev_loc,
  input  logic                      cmt_valid,
  input  logic [SW-1:0]             cmt_slot,
  input  logic [AW-1:0]             cmt_arch,
  input  logic                      flush,
  input  logic                      qry_valid,
  input  logic [SW-1:0]             qry_slot,
  output logic                      wb_valid,
  output logic                      wb_short
);
  logic                 room_ok;
  logic                 fire;
  logic [SW:0]          free_cnt;
  logic [ARCH_REGS-1:0] loc_vec;
  logic [SLOTS-1:0]     ren_vec;

  assign ren_ready = ~flush & room_ok;
  assign fire      = ren_valid & ren_ready;

  rn_alloc #(.SLOTS(SLOTS), .LANES(LANES)) u_alloc (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fire(fire),
    .cmt_valid(cmt_valid), .dst_en(ren_dst_en),
    .new_slot(dst_slot), .room_ok(room_ok), .free_cnt(free_cnt)
  );

  rn_map #(.ARCH_REGS(ARCH_REGS), .SLOTS(SLOTS), .LANES(LANES)) u_map (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fire(fire),
    .dst_en(ren_dst_en), .dst(ren_dst), .src0(ren_src0), .src1(ren_src1),
    .new_slot(dst_slot), .cmt_valid(cmt_valid), .cmt_slot(cmt_slot), .cmt_arch(cmt_arch),
    .s0_slot(src0_slot), .s0_loc(src0_loc), .s1_slot(src1_slot), .s1_loc(src1_loc),
    .old_slot(prev_slot), .old_loc(prev_loc), .loc_vec(loc_vec)
  );

  rn_superseded #(.SLOTS(SLOTS), .LANES(LANES)) u_sup (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fire(fire),
    .dst_en(ren_dst_en), .new_slot(dst_slot), .old_slot(prev_slot), .old_loc(prev_loc),
    .qry_valid(qry_valid), .qry_slot(qry_slot),
    .wb_valid(wb_valid), .wb_short(wb_short), .flags(ren_vec)
  );
endmodule

// File: rtl/rn_chk.sv
module rn_chk #(
  parameter int ARCH_REGS = rn_pkg::DEF_ARCH_REGS,
  parameter int SLOTS     = rn_pkg::DEF_SLOTS,
  parameter int LANES     = rn_pkg::DEF_LANES,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int SW = $clog2(SLOTS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      flush,
  input logic                      ren_ready,
  input logic                      fire,
  input logic [LANES-1:0]          ren_dst_en,
  input logic [LANES-1:0][AW-1:0]  ren_dst,
  input logic [LANES-1:0][SW-1:0]  dst_slot,
  input logic [LANES-1:0][SW-1:0]  prev_slot,
  input logic [LANES-1:0]          prev_loc,
  input logic                      qry_valid,
  input logic                      wb_valid,
  input logic [SW:0]               free_cnt,
  input logic [ARCH_REGS-1:0]      loc_vec,
  input logic [SLOTS-1:0]          ren_vec
);
  localparam logic [SW:0] SLOTS_V = SLOTS[SW:0];

  // R4
  free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= SLOTS_V);

  // R10
  flush_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !ren_ready);

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((&loc_vec) && (ren_vec == '0)));

  // R8
  wb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid |=> wb_valid);

  // R8
  wb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_valid |=> !wb_valid);

  for (genvar k = 1; k < LANES; k++) begin : g_lane
    // R3
    consec_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && ren_dst_en[k] && ren_dst_en[k-1]) |->
        dst_slot[k] == ((dst_slot[k-1] == SW'(SLOTS-1)) ? '0 : dst_slot[k-1] + 1'b1));

    // R5
    group_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_dst_en[k] && ren_dst_en[k-1] && ren_dst[k] == ren_dst[k-1]) |->
        (prev_slot[k] == dst_slot[k-1] && !prev_loc[k]));
  end
endmodule

bind rename_table rn_chk #(.ARCH_REGS(ARCH_REGS), .SLOTS(SLOTS), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .ren_ready(ren_ready), .fire(fire),
  .ren_dst_en(ren_dst_en), .ren_dst(ren_dst), .dst_slot(dst_slot),
  .prev_slot(prev_slot), .prev_loc(prev_loc), .qry_valid(qry_valid),
  .wb_valid(wb_valid), .free_cnt(free_cnt), .loc_vec(loc_vec), .ren_vec(ren_vec)
);

// File: tb/sim_rename_table.sv
module sim_rename_table;
  localparam int ARCH  = 8;
  localparam int SLOTS = 16;
  localparam int LANES = 2;
  localparam int AW = $clog2(ARCH);
  localparam int SW = $clog2(SLOTS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                      rv, fl, cv, qv;
  logic [LANES-1:0]          de;
  logic [LANES-1:0][AW-1:0]  dst, s0, s1;
  logic [SW-1:0]             cs, qs;
  logic [AW-1:0]             ca;
  logic                      ren_ready, wb_valid, wb_short;
  logic [LANES-1:0][SW-1:0]  src0_slot, src1_slot, dst_slot, prev_slot;
  logic [LANES-1:0]          src0_loc, src1_loc, prev_loc;

  rename_table #(.ARCH_REGS(ARCH), .SLOTS(SLOTS), .LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .ren_valid(rv), .ren_ready(ren_ready),
    .ren_dst_en(de), .ren_dst(dst), .ren_src0(s0), .ren_src1(s1),
    .src0_slot(src0_slot), .src0_loc(src0_loc), .src1_slot(src1_slot), .src1_loc(src1_loc),
    .dst_slot(dst_slot), .prev_slot(prev_slot), .prev_loc(prev_loc),
    .cmt_valid(cv), .cmt_slot(cs), .cmt_arch(ca), .flush(fl),
    .qry_valid(qv), .qry_slot(qs), .wb_valid(wb_valid), .wb_short(wb_short)
  );

  // Reference state
  int m_slot [ARCH];
  int m_loc  [ARCH];
  int m_ren  [SLOTS];
  int slot_arch [SLOTS];
  int m_head, m_free, m_tail;
  int e_dst [LANES];
  int e_pslot [LANES];
  int e_ploc [LANES];
  int e_need;
  bit e_fire;
  int checks = 0;
  int fails = 0;
  string q_tag = "R8";

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int a = 0; a < ARCH; a++) begin m_slot[a] = 0; m_loc[a] = 1; end
    for (int s = 0; s < SLOTS; s++) begin m_ren[s] = 0; slot_arch[s] = 0; end
    m_head = 0; m_free = SLOTS; m_tail = 0;
  endtask

  task automatic idle();
    rv = 0; fl = 0; cv = 0; qv = 0; de = '0; dst = '0; s0 = '0; s1 = '0;
    cs = '0; qs = '0; ca = '0;
  endtask

  // Check the combinational outputs against the model (inputs already driven).
  task automatic settle();
    int w_slot [ARCH];
    int w_loc  [ARCH];
    int cnt;
    bit rdy;
    bit byp;
    #1;
    cnt = 0;
    for (int k = 0; k < LANES; k++) if (de[k]) cnt++;
    rdy = !fl && (m_free >= cnt);
    chk(fl ? "R10 ready during flush" : "R4 ready", int'(ren_ready), int'(rdy));
    for (int a = 0; a < ARCH; a++) begin w_slot[a] = m_slot[a]; w_loc[a] = m_loc[a]; end
    e_need = cnt;
    cnt = 0;
    for (int k = 0; k < LANES; k++) begin
      byp = 0;
      for (int j = 0; j < k; j++) if (de[j] && dst[j] == s0[k]) byp = 1;
      chk(byp ? "R5 src0 slot" : "R2 src0 slot", int'(src0_slot[k]), w_slot[s0[k]]);
      chk(byp ? "R5 src0 loc" : "R2 src0 loc", int'(src0_loc[k]), w_loc[s0[k]]);
      byp = 0;
      for (int j = 0; j < k; j++) if (de[j] && dst[j] == s1[k]) byp = 1;
      chk(byp ? "R5 src1 slot" : "R2 src1 slot", int'(src1_slot[k]), w_slot[s1[k]]);
      chk(byp ? "R5 src1 loc" : "R2 src1 loc", int'(src1_loc[k]), w_loc[s1[k]]);
      e_dst[k] = (m_head + cnt) % SLOTS;
      chk("R3 dst slot", int'(dst_slot[k]), e_dst[k]);
      e_pslot[k] = w_slot[dst[k]];
      e_ploc[k]  = w_loc[dst[k]];
      chk("R6 prev slot", int'(prev_slot[k]), e_pslot[k]);
      chk("R6 prev loc", int'(prev_loc[k]), e_ploc[k]);
      if (de[k]) begin
        w_slot[dst[k]] = e_dst[k];
        w_loc[dst[k]]  = 0;
        cnt++;
      end
    end
    e_fire = rv && rdy;
  endtask

  // Clock edge, model update, then the query answer on the next cycle.
  task automatic advance();
    bit nq_v;
    int nq_s;
    nq_v = qv;
    nq_s = qv ? m_ren[qs] : 0;
    @(posedge clk);
    if (fl) model_clear();
    else begin
      if (cv) begin
        if (m_loc[ca] == 0 && m_slot[ca] == int'(cs)) m_loc[ca] = 1;
        m_free++;
        m_tail = (m_tail + 1) % SLOTS;
      end
      if (e_fire) begin
        for (int k = 0; k < LANES; k++) begin
          if (de[k]) begin
            m_ren[e_dst[k]] = 0;
            if (e_ploc[k] == 0) m_ren[e_pslot[k]] = 1;
            m_slot[dst[k]] = e_dst[k];
            m_loc[dst[k]]  = 0;
            slot_arch[e_dst[k]] = int'(dst[k]);
          end
        end
        m_head = (m_head + e_need) % SLOTS;
        m_free = m_free - e_need;
      end
    end
    @(negedge clk);
    chk("R8 wb valid", int'(wb_valid), int'(nq_v));
    if (nq_v) chk(q_tag, int'(wb_short), nq_s);
  endtask

  task automatic step();
    settle();
    advance();
  endtask

  task automatic commit_oldest();
    cv = 1;
    cs = SW'(m_tail);
    ca = AW'(slot_arch[m_tail]);
  endtask

  task automatic query(int slot, int exp, string tag);
    idle();
    qv = 1; qs = SW'(slot);
    step();
    chk(tag, int'(wb_short), exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle();
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every map entry and of the allocator
    for (int a = 0; a < ARCH; a++) begin
      idle();
      s0[0] = AW'(a); s1[1] = AW'(a);
      settle();
      chk("R1 reset loc", int'(src0_loc[0]), 1);
      chk("R1 reset slot", int'(src1_slot[1]), 0);
      if (a == 0) chk("R1 first slot", int'(dst_slot[0]), 0);
      advance();
    end

    // Register 1 gets slot 0, then slot 1
    idle(); rv = 1; de = 2'b01; dst[0] = 1; step();
    idle(); rv = 1; de = 2'b01; dst[0] = 1; qv = 1; qs = 0; step();
    chk("R8 answer from before the edge", int'(wb_short), 0);
    query(0, 1, "R6 superseded");
    query(1, 0, "R6 still current");

    // R9: commit of slot 0 does not match register 1 (maps slot 1)
    idle(); commit_oldest(); step();
    idle(); s0[0] = 1; settle();
    chk("R9 mismatch keeps loc", int'(src0_loc[0]), 0);
    chk("R9 mismatch keeps slot", int'(src0_slot[0]), 1);
    advance();
    idle(); commit_oldest(); step();
    idle(); s0[0] = 1; settle();
    chk("R9 matching commit", int'(src0_loc[0]), 1);
    advance();

    // R5/R11: both lanes write register 1, lane 1 reads it
    idle(); rv = 1; de = 2'b11; dst[0] = 1; dst[1] = 1; s0[1] = 1; settle();
    chk("R11 prev loc", int'(prev_loc[0]), 1);
    chk("R5 bypass slot", int'(src0_slot[1]), 2);
    chk("R5 bypass loc", int'(src0_loc[1]), 0);
    chk("R5 prev slot", int'(prev_slot[1]), 2);
    advance();
    query(1, 0, "R11 no flag from register-file mapping");
    query(2, 1, "R6 same-group supersede");

    // R7: cycle register 2 through 15 slots so slot 2 is reallocated
    for (int i = 0; i < 15; i++) begin
      idle(); rv = 1; de = 2'b01; dst[0] = 2; commit_oldest(); step();
    end
    query(2, 0, "R7 cleared on reallocation");

    // R4: fill every free slot, then back-pressure
    for (int i = 0; i < 7; i++) begin
      idle(); rv = 1; de = 2'b11; dst[0] = AW'(i); dst[1] = AW'(i + 1); step();
    end
    idle(); rv = 1; de = 2'b11; dst[0] = 3; settle();
    chk("R4 full", int'(ren_ready), 0);
    advance();
    idle(); rv = 1; de = 2'b01; dst[0] = 3; settle();
    chk("R4 one short", int'(ren_ready), 0);
    advance();
    idle(); rv = 1; settle();
    chk("R4 zero destinations", int'(ren_ready), 1);
    advance();

    // R10: flush with a pending group and commit
    idle(); fl = 1; rv = 1; de = 2'b11; commit_oldest(); settle();
    chk("R10 ready low", int'(ren_ready), 0);
    advance();
    for (int a = 0; a < ARCH; a++) begin
      idle(); s0[0] = AW'(a); settle();
      chk("R10 loc restored", int'(src0_loc[0]), 1);
      if (a == 0) chk("R10 allocator restored", int'(dst_slot[0]), 0);
      advance();
    end
    for (int s = 0; s < SLOTS; s++) query(s, 0, "R10 flags cleared");

    // Mixed run against the model
    for (int i = 0; i < 3000; i++) begin
      idle();
      fl = ($urandom % 60) == 0;
      rv = ($urandom % 4) != 0;
      de = LANES'($urandom);
      for (int k = 0; k < LANES; k++) begin
        dst[k] = AW'($urandom);
        s0[k]  = AW'($urandom);
        s1[k]  = AW'($urandom);
      end
      if ((SLOTS - m_free) > 0 && ($urandom % 5) < 3) begin
        commit_oldest();
        if (($urandom % 8) == 0) ca = AW'($urandom);
      end
      qv = ($urandom % 2) == 0;
      qs = SW'($urandom);
      step();
    end

    idle();
    @(negedge clk);
    finish_run();
  end
endmodule